// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Event Line Controller

This block watches a bank of 24 external line positions, 22 of them implemented, and turns chosen signal edges into requests. Each line can be set to react to a rising edge, a falling edge or both. A qualifying edge on a line can do two things. It can latch an interrupt request that stays up until software clears it. It can also emit a single-cycle wakeup event pulse that is never latched. Software can also raise either kind of request on any line by writing a trigger register.

Every raw line passes through a two-flop synchroniser before edge detection. Software reaches six 32-bit registers through a zero-wait APB-style slave port. The transfer has a setup phase with `psel` high, then an access phase with `psel` and `penable` both high, and a write takes effect at the clock edge that ends the access phase.

The register offsets are:

- 0x00: interrupt enable
- 0x04: event enable
- 0x08: rising select
- 0x0C: falling select
- 0x10: software trigger
- 0x14: pending

Line positions 19 and 20 are holes in every register.

Top module: `edge_line_ctrl`

## Requirements
- R1: After reset all six registers read 0, and `irq_out` and `evt_out` are 0. Reads return the register at its offset, and any other offset reads 0.
- R2: Bits 19, 20 and 24–31 are not implemented in any register. They always read 0 and ignore writes. Writing 0xFFFFFFFF reads back as 0x00E7FFFF. Line positions 19 and 20 never raise `irq_out` or `evt_out`.
- R3: In the select registers a 1 enables that edge for the line, and both may be enabled at once. A line change driven before clock edge k is acted on at edge k+2. So the pending bit and the event pulse first appear after edge k+2.
- R4: A selected edge sets the line's pending bit only when the line's interrupt enable bit is 1. `irq_out[i]` is 1 exactly while pending bit i and interrupt enable bit i are both 1.
- R5: A selected edge on a line whose event enable bit is 1 drives `evt_out[i]` high for exactly one cycle. The event path alone never sets a pending bit.
- R6: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. Clearing a pending bit also clears the matching software trigger bit.
- R7: Writing 1 to a software trigger bit that reads 0 does three things. The bit then reads 1. The pending bit is set if interrupts are enabled on that line. An event pulse is emitted if events are enabled on that line. Writing 1 to a software trigger bit that already reads 1 does nothing.
- R8: A rising edge acted on in the same cycle as a write to the rising select register is judged against the old value ORed with the written value, so the pending bit is still set. A falling edge in the same cycle as a write to the falling select register is judged only against the old value.
- R9: If a new trigger and a write-1 clear reach the same pending bit in one cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 8 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in access phase |
| line_in | input | 24 | Raw external lines, asynchronous |
| irq_out | output | 24 | Per-line interrupt request |
| evt_out | output | 24 | Per-line one-cycle event pulse |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a synchronised edge and a bus write: either a write to a select register or a write-1 clear of the pending bit that the edge would set. The bench provokes each collision by changing a line, waiting one clock, and then starting a two-phase write. That timing makes the write's access edge the very edge at which the line change is acted on. The result is judged by reading back the pending and software trigger registers and observing `irq_out`. A rising edge must still latch, a falling edge must not, and a set must beat a clear.

// File: rtl/edge_line_ctrl.sv
module edge_line_ctrl #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int NL = 24,
  parameter logic [DW-1:0] IMPL = 32'h00E7_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  input  logic [NL-1:0] line_in,
  output logic [NL-1:0] irq_out,
  output logic [NL-1:0] evt_out
);
  localparam logic [AW-1:0] A_IEN = AW'(8'h00);
  localparam logic [AW-1:0] A_EEN = AW'(8'h04);
  localparam logic [AW-1:0] A_RSE = AW'(8'h08);
  localparam logic [AW-1:0] A_FSE = AW'(8'h0C);
  localparam logic [AW-1:0] A_SWT = AW'(8'h10);
  localparam logic [AW-1:0] A_PND = AW'(8'h14);
  localparam logic [NL-1:0] IMPL_L = IMPL[NL-1:0];

  logic [NL-1:0] s1_q, s2_q, s3_q;
  logic [NL-1:0] imr_q, emr_q, rse_q, fse_q, swt_q, pend_q;
  logic [NL-1:0] wdat, rse_eff, rise, fall, sw_new, clr, trig;
  logic          wr;
  logic          unused_hi;

  assign wr        = psel & penable & pwrite;
  assign wdat      = pwdata[NL-1:0] & IMPL_L;
  assign unused_hi = ^pwdata[DW-1:NL];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= line_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end

  assign rise    = s2_q & ~s3_q;
  assign fall    = ~s2_q & s3_q;
  assign rse_eff = (wr && paddr == A_RSE) ? (rse_q | wdat) : rse_q;
  assign sw_new  = (wr && paddr == A_SWT) ? (wdat & ~swt_q) : '0;
  assign clr     = (wr && paddr == A_PND) ? wdat : '0;
  assign trig    = ((rise & rse_eff) | (fall & fse_q) | sw_new) & IMPL_L;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      imr_q  <= '0;
      emr_q  <= '0;
      rse_q  <= '0;
      fse_q  <= '0;
      swt_q  <= '0;
      pend_q <= '0;
      evt_out <= '0;
    end else begin
      if (wr && paddr == A_IEN) imr_q <= wdat;
      if (wr && paddr == A_EEN) emr_q <= wdat;
      if (wr && paddr == A_RSE) rse_q <= wdat;
      if (wr && paddr == A_FSE) fse_q <= wdat;
      swt_q   <= (swt_q & ~clr) | sw_new;
      pend_q  <= (pend_q & ~clr) | (trig & imr_q);
      evt_out <= trig & emr_q;
    end

  assign irq_out = pend_q & imr_q;

  always_comb begin
    prdata = '0;
    if (psel && !pwrite)
      case (paddr)
        A_IEN:   prdata = DW'(imr_q);
        A_EEN:   prdata = DW'(emr_q);
        A_RSE:   prdata = DW'(rse_q);
        A_FSE:   prdata = DW'(fse_q);
        A_SWT:   prdata = DW'(swt_q);
        A_PND:   prdata = DW'(pend_q);
        default: prdata = '0;
      endcase
  end
endmodule

module line_chk #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int NL = 24,
  parameter logic [DW-1:0] IMPL = 32'h00E7_FFFF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [AW-1:0] paddr,
  input logic [NL-1:0] wbits,
  input logic [DW-1:0] prdata,
  input logic [NL-1:0] imr,
  input logic [NL-1:0] emr,
  input logic [NL-1:0] pend,
  input logic [NL-1:0] swt,
  input logic [NL-1:0] evt
);
  logic          wr_pnd;
  logic [NL-1:0] clr_bits;
  assign wr_pnd   = psel && penable && pwrite && paddr == AW'(8'h14);
  assign clr_bits = wr_pnd ? wbits : '0;

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prdata & ~IMPL) == '0);

  // R6
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend) & ~pend & ~$past(clr_bits)) == '0);

  // R4
  pend_needs_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~$past(imr)) == '0);

  // R5
  evt_needs_een_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & ~$past(emr)) == '0);

  // R6
  swt_follow_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pnd |=> (swt & $past(wbits)) == '0);

  // R2
  hole_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & ~IMPL[NL-1:0]) == '0);
endmodule

bind edge_line_ctrl line_chk #(.DW(DW), .AW(AW), .NL(NL), .IMPL(IMPL)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .wbits(pwdata[NL-1:0]), .prdata(prdata), .imr(imr_q),
  .emr(emr_q), .pend(pend_q), .swt(swt_q), .evt(evt_out)
);

// File: tb/sim_edge_line_ctrl.sv
module sim_edge_line_ctrl;
  localparam logic [31:0] IMPL = 32'h00E7_FFFF;
  localparam logic [7:0] A_IEN = 8'h00, A_EEN = 8'h04, A_RSE = 8'h08,
                         A_FSE = 8'h0C, A_SWT = 8'h10, A_PND = 8'h14;

  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic [23:0] line_in = 0, irq_out, evt_out;
  int errs = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  edge_line_ctrl u0 (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .line_in(line_in), .irq_out(irq_out), .evt_out(evt_out));

  function automatic logic [23:0] exp_trig(logic [23:0] o, logic [23:0] n,
                                           logic [23:0] r, logic [23:0] f);
    return ((~o & n & r) | (o & ~n & f)) & IMPL[23:0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rdchk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [23:0] im, em, rs, fs, nl, t;
    void'($urandom(32'd2024));
    @(negedge clk); step(2); rst_n = 1; step(1);
    // R1 reset values
    for (int a = 0; a < 6; a++) rdchk("R1 reset reg", 8'(a * 4), 0);
    chk("R1 reset irq", irq_out, 0);
    chk("R1 reset evt", evt_out, 0);
    // R2 holes
    wr(A_IEN, 32'hFFFF_FFFF); rdchk("R2 ien holes", A_IEN, IMPL);
    wr(A_RSE, 32'hFFFF_FFFF); rdchk("R2 rse holes", A_RSE, IMPL);
    wr(A_EEN, 32'hFFFF_FFFF); wr(A_FSE, 32'hFFFF_FFFF);
    line_in = 24'h18_0000; step(3);
    chk("R2 hole evt", evt_out, 0); chk("R2 hole irq", irq_out, 0);
    rdchk("R1 bad offset", 8'h18, 0);
    wr(A_IEN, 0); wr(A_EEN, 0); wr(A_RSE, 0); wr(A_FSE, 0);
    line_in = 0; step(4);
    // R3 rising latency
    wr(A_IEN, 32'h8); wr(A_RSE, 32'h8);
    line_in[3] = 1; step(2);
    chk("R3 not yet", irq_out, 0);
    step(1); chk("R3 rise latch", irq_out, 24'h8);
    wr(A_PND, 32'h8); chk("R6 clear", irq_out, 0);
    // R3 falling and both
    wr(A_IEN, 32'h288); wr(A_FSE, 32'h80); wr(A_RSE, 32'h208); wr(A_FSE, 32'h280);
    line_in[7] = 1; step(4); chk("R3 rise ignored on fall-only", irq_out, 0);
    line_in[7] = 0; step(3); chk("R3 fall latch", irq_out, 24'h80);
    wr(A_PND, 32'h80);
    line_in[9] = 1; step(3); chk("R3 both rise", irq_out, 24'h200);
    wr(A_PND, 32'h200);
    line_in[9] = 0; step(3); chk("R3 both fall", irq_out, 24'h200);
    wr(A_PND, 32'h200);
    // R4 masked
    wr(A_RSE, 32'h400); wr(A_IEN, 0);
    line_in[10] = 1; step(4);
    rdchk("R4 masked no pending", A_PND, 0);
    // R5 event
    wr(A_EEN, 32'h1000); wr(A_RSE, 32'h1000);
    line_in[12] = 1; step(3);
    chk("R5 evt high", evt_out, 24'h1000);
    step(1); chk("R5 evt one cycle", evt_out, 0);
    rdchk("R5 no pending", A_PND, 0);
    // R7 software trigger
    wr(A_IEN, 32'h4); wr(A_EEN, 32'h4);
    wr(A_SWT, 32'h4);
    chk("R7 sw evt", evt_out, 24'h4); chk("R7 sw irq", irq_out, 24'h4);
    step(1); chk("R7 sw evt one cycle", evt_out, 0);
    rdchk("R7 swt reads 1", A_SWT, 32'h4);
    wr(A_PND, 0); rdchk("R6 write 0 keeps", A_PND, 32'h4);
    wr(A_PND, 32'h4);
    rdchk("R6 pending cleared", A_PND, 0); rdchk("R6 swt cleared", A_SWT, 0);
    wr(A_IEN, 0); wr(A_SWT, 32'h4);
    rdchk("R7 masked sw no pend", A_PND, 0);
    wr(A_IEN, 32'h4); wr(A_SWT, 32'h4);
    rdchk("R7 rewrite 1 no effect", A_PND, 0);
    // R8 coincident select writes
    wr(A_IEN, 32'hC000); wr(A_RSE, 0); wr(A_FSE, 0); wr(A_EEN, 0);
    line_in[15] = 1; step(4);
    line_in[14] = 1; step(1); wr(A_RSE, 32'h4000);
    chk("R8 rise during rse write", irq_out, 24'h4000);
    wr(A_PND, 32'hFFFFFF);
    line_in[15] = 0; step(1); wr(A_FSE, 32'h8000);
    step(2); chk("R8 fall during fse write", irq_out, 0);
    // R9 set beats clear
    wr(A_IEN, 32'h20); wr(A_RSE, 32'h20); wr(A_FSE, 0);
    wr(A_SWT, 32'h20); chk("R9 pre pending", irq_out, 24'h20);
    line_in[5] = 1; step(1); wr(A_PND, 32'h20);
    chk("R9 set wins", irq_out, 24'h20);
    rdchk("R9 swt cleared", A_SWT, 0);
    wr(A_PND, 32'h20); chk("R9 later clear", irq_out, 0);
    // random
    for (int i = 0; i < 40; i++) begin
      im = 24'($urandom); em = 24'($urandom);
      rs = 24'($urandom); fs = 24'($urandom);
      nl = 24'($urandom);
      wr(A_IEN, 32'(im)); wr(A_EEN, 32'(em));
      wr(A_RSE, 32'(rs)); wr(A_FSE, 32'(fs));
      wr(A_PND, 32'hFFFFFF);
      t = exp_trig(line_in, nl, rs, fs);
      line_in = nl; step(3);
      chk("R5 random evt", evt_out, t & em);
      chk("R4 random irq", irq_out, t & im & IMPL[23:0]);
      step(1);
      rdchk("R3 random pending", A_PND, 32'(t & im & IMPL[23:0]));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule